// File: doc/BRIEF.md
# Event Bank Linker

The event bank linker collects the per-event data banks produced inside one preprocessing device and serialises them, word by word, onto a single output stream. Five sources feed it: one control source carrying event information and four data sources carrying cluster records, digitised ADC samples, raw (non-zero-suppressed) samples and pedestal values. Each source offers one bank per event through a valid/ready handshake, with a last flag on the final word of the bank.

For every event the linker visits the sources in a fixed order (info, cluster, ADC, raw, pedestal), copies each enabled bank to the output in arrival order and skips disabled sources entirely. The info, cluster and ADC banks are always part of an event. The raw and pedestal banks join only when their enable input is high; in the default configuration both enables are tied low. Every output word carries a 4-bit control field beside the data word. The field is 1111 on the first word of a bank and 0000 on every word that continues one. A small first-in first-out buffer sits between the sequencer and the output, so back-pressure from the consumer stalls the selected source once the buffer fills, and no word is lost.

Top module: `evlink_top`

## Requirements
- R1: After reset the output holds no word (out_valid low), and src_ready equals 5'b00001, so only the info source is offered a handshake.
- R2: Source bit positions are info=0, cluster=1, ADC=2, raw=3, pedestal=4. Within an event, banks leave in ascending bit order.
- R3: The info, cluster and ADC banks are emitted for every event whatever the enable inputs hold.
- R4: The raw bank (bit 3) is emitted only when raw_en is 1, and the pedestal bank (bit 4) only when ped_en is 1. A disabled source never sees src_ready high, and any word it presents never reaches the output.
- R5: out_mark is 4'b1111 on the first word of each bank, including a one-word bank, and 4'b0000 on every other word.
- R6: The words of a bank leave in the order they were accepted, with none dropped or repeated.
- R7: The info bank of the next event is not accepted until the last word of the current event's final enabled bank has been accepted.
- R8: While out_ready is low the output word and mark hold steady. At most FIFO_DEPTH words are buffered, and with the buffer full every src_ready bit is low.
- R9: raw_en and ped_en are sampled while the linker waits for an event's first info word. A change made later in that event applies from the next event.
- R10: At most one src_ready bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_en | input | 1 | Include the raw-sample bank (tie low by default) |
| ped_en | input | 1 | Include the pedestal bank (tie low by default) |
| src_valid | input | 5 | Per-source word valid, bit order as in R2 |
| src_last | input | 5 | Per-source last word of the bank |
| src_data | input | 5*DATA_W | Per-source data words, source n in bits n*DATA_W upward |
| src_ready | output | 5 | Per-source word accepted this cycle when valid |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_mark | output | 4 | Bank control field: 1111 starts a bank, 0000 continues it |
| out_data | output | DATA_W | Output data word |

## Verification
Two situations are hard to reach from the ports. The first is a source that is ready early: the info source already presents the next event's first word while a later bank of the current event is still stalled behind a full buffer. To get there, every source runs as an independent stream across several events, and the output is throttled with a pseudo-random ready pattern. The second is an enable that changes in the middle of an event. The bench raises raw_en and ped_en as soon as the info bank completes, while both disabled sources hold a poisoned word valid, and then expects neither bank in that event.

// File: rtl/evlink_pkg.sv
package evlink_pkg;

    localparam int NSRC = 5;

    typedef enum logic [2:0] {
        BK_INFO = 3'd0,
        BK_CLUS = 3'd1,
        BK_ADC  = 3'd2,
        BK_RAW  = 3'd3,
        BK_PED  = 3'd4
    } bank_e;

    localparam logic [3:0]      MARK_START = 4'b1111;
    localparam logic [3:0]      MARK_CONT  = 4'b0000;
    localparam logic [NSRC-1:0] FIXED_ON   = 5'b00111;

    // first enabled bank after cur; wraps to info when none remains
    function automatic bank_e next_bank(bank_e cur, logic [NSRC-1:0] en);
        bank_e r;
        r = BK_INFO;
        for (int k = NSRC - 1; k > 0; k--) begin
            if (k > int'(cur) && en[k]) r = bank_e'(k[2:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/evlink_seq.sv
module evlink_seq
    import evlink_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_en,
    input  logic            ped_en,
    input  logic [NSRC-1:0] src_valid,
    input  logic [NSRC-1:0] src_last,
    input  logic            space,
    output logic [NSRC-1:0] src_ready,
    output logic            push,
    output logic [3:0]      push_mark,
    output bank_e           sel,
    output logic [NSRC-1:0] en_latched
);

    typedef struct packed {
        bank_e           cur;
        logic            first;
        logic [NSRC-1:0] en;
    } seq_t;

    seq_t            st_d, st_q;
    logic            idle;
    logic            fire;
    logic [NSRC-1:0] en_live;
    logic [NSRC-1:0] en_eff;

    always_comb begin
        en_live         = FIXED_ON;
        en_live[BK_RAW] = raw_en;
        en_live[BK_PED] = ped_en;

        idle   = (st_q.cur == BK_INFO) && st_q.first;
        en_eff = idle ? en_live : st_q.en;
        fire   = src_valid[st_q.cur] && space;

        st_d    = st_q;
        st_d.en = en_eff;
        if (fire) begin
            st_d.first = src_last[st_q.cur];
            if (src_last[st_q.cur]) st_d.cur = next_bank(st_q.cur, en_eff);
        end

        src_ready  = space ? (NSRC'(1) << st_q.cur) : '0;
        push       = fire;
        push_mark  = st_q.first ? MARK_START : MARK_CONT;
        sel        = st_q.cur;
        en_latched = st_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur   <= BK_INFO;
            st_q.first <= 1'b1;
            st_q.en    <= FIXED_ON;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evlink_fifo.sv
module evlink_fifo #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    output logic                       wr_space,
    input  logic                       rd_en,
    output logic                       rd_valid,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t fs_d, fs_q;
    logic  full, empty, do_wr, do_rd;

    always_comb begin
        full  = (fs_q.cnt == CW'(DEPTH));
        empty = (fs_q.cnt == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;

        fs_d = fs_q;
        if (do_wr) begin
            fs_d.mem[fs_q.wp] = wr_data;
            fs_d.wp = (fs_q.wp == PW'(DEPTH - 1)) ? '0 : fs_q.wp + 1'b1;
        end
        if (do_rd) begin
            fs_d.rp = (fs_q.rp == PW'(DEPTH - 1)) ? '0 : fs_q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   fs_d.cnt = fs_q.cnt + 1'b1;
            2'b01:   fs_d.cnt = fs_q.cnt - 1'b1;
            default: fs_d.cnt = fs_q.cnt;
        endcase

        wr_space = !full;
        rd_valid = !empty;
        rd_data  = fs_q.mem[fs_q.rp];
        level    = fs_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

endmodule

// File: rtl/evlink_top.sv
module evlink_top
    import evlink_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   raw_en,
    input  logic                   ped_en,
    input  logic [NSRC-1:0]        src_valid,
    input  logic [NSRC-1:0]        src_last,
    input  logic [NSRC*DATA_W-1:0] src_data,
    output logic [NSRC-1:0]        src_ready,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [3:0]             out_mark,
    output logic [DATA_W-1:0]      out_data
);

    localparam int WORD_W = 4 + DATA_W;
    localparam int CW     = $clog2(FIFO_DEPTH + 1);

    logic [DATA_W-1:0] src_word [NSRC];
    logic              space;
    logic              push;
    logic [3:0]        push_mark;
    bank_e             sel;
    logic [NSRC-1:0]   seq_en;
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     fifo_level;

    for (genvar g = 0; g < NSRC; g++) begin : g_unpack
        assign src_word[g] = src_data[g*DATA_W +: DATA_W];
    end

    evlink_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_en     (raw_en),
        .ped_en     (ped_en),
        .src_valid  (src_valid),
        .src_last   (src_last),
        .space      (space),
        .src_ready  (src_ready),
        .push       (push),
        .push_mark  (push_mark),
        .sel        (sel),
        .en_latched (seq_en)
    );

    evlink_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  ({push_mark, src_word[sel]}),
        .wr_space (space),
        .rd_en    (out_ready),
        .rd_valid (out_valid),
        .rd_data  (head),
        .level    (fifo_level)
    );

    assign out_mark = head[WORD_W-1 -: 4];
    assign out_data = head[DATA_W-1:0];

endmodule

// File: rtl/evlink_chk.sv
module evlink_chk
    import evlink_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSRC-1:0]            src_valid,
    input logic [NSRC-1:0]            src_last,
    input logic [NSRC-1:0]            src_ready,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [3:0]                 out_mark,
    input logic [DATA_W-1:0]          out_data,
    input logic [NSRC-1:0]            seq_en,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);

    // R10
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));

    // R4
    raw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready[BK_RAW] |-> seq_en[BK_RAW]);

    // R4
    ped_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready[BK_PED] |-> seq_en[BK_PED]);

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mark));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

    // R8
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level == ($clog2(DEPTH+1))'(DEPTH) |-> src_ready == '0);

    // R2
    info_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid[BK_INFO] && src_ready[BK_INFO] && src_last[BK_INFO] |=> !src_ready[BK_INFO]);

endmodule

bind evlink_top evlink_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_last   (src_last),
    .src_ready  (src_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_mark   (out_mark),
    .out_data   (out_data),
    .seq_en     (seq_en),
    .fifo_level (fifo_level)
);

// File: tb/tb_evlink_top.sv
module tb_evlink_top;
    import evlink_pkg::*;

    localparam int DW    = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                 raw_en = 1'b0, ped_en = 1'b0;
    logic [NSRC-1:0]      s_valid = '0, s_last = '0, src_ready;
    logic [DW-1:0]        s_data [NSRC];
    logic [NSRC*DW-1:0]   src_data;
    logic                 out_valid, out_ready = 1'b0;
    logic [3:0]           out_mark;
    logic [DW-1:0]        out_data;

    for (genvar g = 0; g < NSRC; g++) begin : g_pack
        assign src_data[g*DW +: DW] = s_data[g];
    end

    evlink_top #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .raw_en(raw_en), .ped_en(ped_en),
        .src_valid(s_valid), .src_last(s_last), .src_data(src_data),
        .src_ready(src_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_mark(out_mark), .out_data(out_data)
    );

    int checks = 0, fails = 0, cyc = 0, rdy_mode = 0, acc_total = 0;
    int ev_base = 0, onehot_bad = 0;
    logic [DW+3:0]   sb [$];
    logic [NSRC-1:0] stream_done = '0;

    function automatic logic [DW-1:0] word(int s, int e, int i);
        return {s[2:0], e[6:0], i[5:0]};
    endfunction

    function automatic int blen(int e, int s, int seed);
        return 1 + ((e * 7 + s * 3 + seed) % 5);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R6 watchdog: actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    // monitor: throttles out_ready and scores every word taken
    initial begin
        logic [7:0]    lfsr;
        logic [DW+3:0] exp;
        lfsr = 8'h5A;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = lfsr[0] | lfsr[2];
                default: out_ready = 1'b0;
            endcase
            if (rst_n && $countones(src_ready) > 1) onehot_bad++;
            if (rst_n && out_valid && out_ready) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R4 R6 unexpected word: actual=%h expected=none", {out_mark, out_data});
                end else begin
                    exp = sb.pop_front();
                    if ({out_mark, out_data} !== exp) begin
                        fails++;
                        $display("FAIL R2 R3 R4 R5 R6 R7 word: actual=%h expected=%h",
                                 {out_mark, out_data}, exp);
                    end
                end
            end
        end
    end

    task automatic drive_word(int s, logic [DW-1:0] d, logic l);
        @(negedge clk);
        s_valid[s] = 1'b1;
        s_data[s]  = d;
        s_last[s]  = l;
        #1;
        while (!src_ready[s]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        acc_total++;
    endtask

    task automatic stream(int s, int nev, int seed);
        for (int e = 0; e < nev; e++) begin
            for (int i = 0; i < blen(e, s, seed); i++)
                drive_word(s, word(s, ev_base + e, i), i == blen(e, s, seed) - 1);
        end
        @(negedge clk);
        s_valid[s] = 1'b0;
        stream_done[s] = 1'b1;
    endtask

    task automatic drain();
        int n = 0;
        while ((sb.size() != 0 || out_valid) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R6 R7 words missing: actual=%0d expected=0", sb.size());
        end
    endtask

    task automatic run_phase(int nev, bit r, bit p, int seed, int mode, bit hold, bit flip);
        logic [NSRC-1:0] en;
        @(negedge clk);
        raw_en = r;
        ped_en = p;
        en = {p, r, 3'b111};
        rdy_mode = mode;
        acc_total = 0;
        stream_done = '0;
        for (int e = 0; e < nev; e++)
            for (int s = 0; s < NSRC; s++)
                if (en[s])
                    for (int i = 0; i < blen(e, s, seed); i++)
                        sb.push_back({(i == 0) ? 4'b1111 : 4'b0000, word(s, ev_base + e, i)});
        for (int s = 0; s < NSRC; s++) begin
            if (!en[s]) begin
                s_valid[s] = 1'b1;
                s_data[s]  = 16'hDEAD;
                s_last[s]  = 1'b1;
            end
        end
        for (int s = 0; s < NSRC; s++) begin
            automatic int ss = s;
            if (en[ss]) fork stream(ss, nev, seed); join_none
        end
        if (flip) begin
            // R9: enables rise once the info bank is in
            fork
                begin
                    wait (stream_done[BK_INFO]);
                    @(negedge clk);
                    raw_en = 1'b1;
                    ped_en = 1'b1;
                end
            join_none
        end
        if (hold) begin
            repeat (20) @(negedge clk);
            #2;
            checks++;
            if (acc_total != DEPTH) begin
                fails++;
                $display("FAIL R8 accepted while stalled: actual=%0d expected=%0d", acc_total, DEPTH);
            end
            checks++;
            if (src_ready !== 5'b00000) begin
                fails++;
                $display("FAIL R8 ready when full: actual=%b expected=00000", src_ready);
            end
            checks++;
            if (!out_valid || {out_mark, out_data} !== {4'b1111, word(0, ev_base, 0)}) begin
                fails++;
                $display("FAIL R5 R8 held head: actual=%b %h expected=1 %h", out_valid,
                         {out_mark, out_data}, {4'b1111, word(0, ev_base, 0)});
            end
            rdy_mode = 0;
        end
        wait fork;
        drain();
        @(negedge clk);
        s_valid = '0;
        ev_base += nev;
    endtask

    initial begin
        for (int s = 0; s < NSRC; s++) s_data[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid after reset: actual=%b expected=0", out_valid);
        end
        checks++;
        if (src_ready !== 5'b00001) begin
            fails++;
            $display("FAIL R1 src_ready after reset: actual=%b expected=00001", src_ready);
        end

        run_phase(3, 1'b0, 1'b0, 1, 0, 1'b0, 1'b0); // R3 default set only
        run_phase(4, 1'b1, 1'b1, 2, 0, 1'b0, 1'b0); // R2 all banks
        run_phase(4, 1'b1, 1'b0, 3, 1, 1'b0, 1'b0); // R4 R7 raw only, throttled
        run_phase(4, 1'b0, 1'b1, 4, 1, 1'b0, 1'b0); // R4 R7 pedestal only, throttled
        run_phase(2, 1'b1, 1'b1, 5, 2, 1'b1, 1'b0); // R8 full stall
        run_phase(1, 1'b0, 1'b0, 6, 0, 1'b0, 1'b1); // R9 mid-event enable change
        run_phase(2, 1'b1, 1'b1, 7, 1, 1'b0, 1'b0); // R9 change applied next event

        checks++;
        if (onehot_bad != 0) begin
            fails++;
            $display("FAIL R10 several ready bits: actual=%0d cycles expected=0", onehot_bad);
        end
        summary();
        $finish;
    end

endmodule